// File: doc/BRIEF.md
# Dual-Doorbell Mailbox Register File

This block is the register storage of a mailbox that links a host processor to a service controller. The host places a command in a bank of four 64-bit command words. The controller returns its answer in a bank of four 64-bit response words. Each side then signals the other through a doorbell register. Each of the two buses reaches the same word map, so either side can read every word. Only the owning side can change a message word.

Each doorbell is reached at three consecutive offsets. The first offset is a plain alias that overwrites the doorbell. The second is a clear alias that ANDs the written value into it. The third is a set alias that ORs the written value into it. Either side can therefore set or clear single bits without a read-modify-write. A doorbell drives the interrupt of the side that receives it, and that interrupt stays high while any bit of the doorbell is set. Doorbell bits are numbered MSB-first. The host uses bit 0 of the controller doorbell to announce a command. The controller uses bit 0 of the host doorbell for a waiting response, bit 1 for a command acknowledge, bit 2 for a power-state exit, bit 3 for a return from reset, bit 4 for a passthrough request and bit 14 for a timer expiry.

Top module: `mbox_regfile`

## Requirements
- R1: Synchronous active-low reset clears every command word, response word and doorbell. Both interrupts are low in the cycle after a reset edge.
- R2: A host write to offsets 0x0 to 0x3 stores the word in command register 0 to 3. From the next cycle that word reads back on both buses.
- R3: A controller write to offsets 0x4 to 0x7 stores the word in response register 0 to 3. From the next cycle that word reads back on both buses.
- R4: A controller write to a command offset and a host write to a response offset leave the target word unchanged.
- R5: A write to offset 0x10 (controller doorbell) or 0x13 (host doorbell) replaces that doorbell with the written value.
- R6: A write to offset 0x11 or 0x14 replaces the controller or host doorbell with its current value ANDed with the written value.
- R7: A write to offset 0x12 or 0x15 replaces the controller or host doorbell with its current value ORed with the written value.
- R8: A read of any of a doorbell's three offsets returns the doorbell's current value.
- R9: irq_to_ctl is high exactly while the controller doorbell is nonzero, and irq_to_host is high exactly while the host doorbell is nonzero. Each interrupt follows a doorbell write one cycle after the write edge, and it falls in that same cycle when the write clears the last bit.
- R10: Reads of unmapped offsets (0x8 to 0xF and 0x16 to 0x1F) return zero, and writes to those offsets change no register.
- R11: When both buses write the same doorbell in one cycle, the controller's update is applied first and the host's update is applied to that result.
- R12: Doorbell bit n is data bit 63-n. Setting bit 0 of the controller doorbell means writing 0x8000_0000_0000_0000 to its set alias, which raises irq_to_ctl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 5 | Host bus word offset |
| h_wr | input | 1 | Host bus write strobe |
| h_wdata | input | 64 | Host bus write data |
| h_rdata | output | 64 | Host bus read data, combinational from h_addr |
| c_addr | input | 5 | Controller bus word offset |
| c_wr | input | 1 | Controller bus write strobe |
| c_wdata | input | 64 | Controller bus write data |
| c_rdata | output | 64 | Controller bus read data, combinational from c_addr |
| irq_to_ctl | output | 1 | Interrupt to the controller, high while its doorbell is nonzero |
| irq_to_host | output | 1 | Interrupt to the host, high while its doorbell is nonzero |

## Verification
The bench builds the block with its default parameters: 64-bit words, a 5-bit offset, four words per direction and doorbells at 0x10 and 0x13. With a 5-bit offset, random addresses cover every mapped word as well as both unmapped holes. Random stimulus forces both buses onto the doorbell offsets in a share of cycles, so same-cycle collisions happen across all nine combinations of write aliases. Directed steps pin down the ordering case and the MSB-first bit mapping.

// File: rtl/mbox_pkg.sv
// Shared types for the mailbox register file.
// Assumes at most 16 message words per direction (idx field is 4 bits).
package mbox_pkg;

    // Which storage an offset selects.
    typedef enum logic [2:0] {
        RG_NONE,
        RG_CMD,
        RG_RSP,
        RG_DB_CTL,
        RG_DB_HOST
    } region_e;

    // Write flavour of a doorbell offset; order matches the offset sequence.
    typedef enum logic [1:0] {
        OP_RW  = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2
    } db_op_e;

    localparam int unsigned IDX_FIELD_W = 4;

    typedef struct packed {
        region_e                 region;
        logic [IDX_FIELD_W-1:0]  idx;
        db_op_e                  op;
    } decode_t;

    // Doorbell bit meanings, MSB-first numbering (bit n is data bit 63-n).
    localparam int unsigned CDB_CMD_READY   = 0;
    localparam int unsigned HDB_RSP_READY   = 0;
    localparam int unsigned HDB_CMD_ACK     = 1;
    localparam int unsigned HDB_PWR_EXIT    = 2;
    localparam int unsigned HDB_CTL_RESET   = 3;
    localparam int unsigned HDB_PASSTHRU    = 4;
    localparam int unsigned HDB_TIMER_EXP   = 14;

endpackage

// File: rtl/mbox_decode.sv
// Offset decoder for one bus.
// Maps a word offset to the storage region, word index and doorbell alias.
// Assumes the regions do not overlap and NUM_MSG <= 16.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W       = 5,
    parameter int unsigned NUM_MSG      = 4,
    parameter int unsigned RSP_BASE     = 4,
    parameter int unsigned CTL_DB_BASE  = 16,
    parameter int unsigned HOST_DB_BASE = 19
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    localparam int unsigned DB_SPAN = 3;

    logic [31:0] a;
    assign a = 32'(addr);

    // Classify the offset into one region and its sub-index.
    always_comb begin
        dec = '{region: RG_NONE, idx: '0, op: OP_RW};
        if (a < NUM_MSG) begin
            dec.region = RG_CMD;
            dec.idx    = IDX_FIELD_W'(a);
        end else if (a >= RSP_BASE && a < RSP_BASE + NUM_MSG) begin
            dec.region = RG_RSP;
            dec.idx    = IDX_FIELD_W'(a - RSP_BASE);
        end else if (a >= CTL_DB_BASE && a < CTL_DB_BASE + DB_SPAN) begin
            dec.region = RG_DB_CTL;
            dec.op     = db_op_e'(2'(a - CTL_DB_BASE));
        end else if (a >= HOST_DB_BASE && a < HOST_DB_BASE + DB_SPAN) begin
            dec.region = RG_DB_HOST;
            dec.op     = db_op_e'(2'(a - HOST_DB_BASE));
        end
    end

endmodule

// File: rtl/mbox_msg_bank.sv
// Bank of message words with a single writing bus.
// Assumes idx is below NUM_MSG whenever we is high.
module mbox_msg_bank #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned NUM_MSG = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_MSG-1:0][DATA_W-1:0]    words
);

    for (genvar i = 0; i < NUM_MSG; i++) begin : g_word
        // Hold one word; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                words[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/mbox_doorbell.sv
// One doorbell register, written by two buses in a fixed order.
// The first port's update is applied before the second port's update.
// The interrupt is high while any doorbell bit is set.
module mbox_doorbell
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_we,
    input  db_op_e            first_op,
    input  logic [DATA_W-1:0] first_wdata,
    input  logic              second_we,
    input  db_op_e            second_op,
    input  logic [DATA_W-1:0] second_wdata,
    output logic [DATA_W-1:0] value,
    output logic              irq
);

    logic [DATA_W-1:0] after_first;
    logic [DATA_W-1:0] after_second;

    function automatic logic [DATA_W-1:0] merge(
        input logic [DATA_W-1:0] cur,
        input db_op_e            op,
        input logic [DATA_W-1:0] wd
    );
        case (op)
            OP_AND:  return cur & wd;
            OP_OR:   return cur | wd;
            default: return wd;
        endcase
    endfunction

    // Chain the two write requests in priority order.
    always_comb begin
        after_first  = first_we  ? merge(value, first_op, first_wdata)         : value;
        after_second = second_we ? merge(after_first, second_op, second_wdata) : after_first;
    end

    // Doorbell storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            value <= after_second;
        end
    end

    assign irq = |value;

endmodule

// File: rtl/mbox_regfile.sv
// Mailbox register file between a host bus and a controller bus.
// Host owns the command words, controller owns the response words; both
// buses reach both doorbells through RW, AND and OR aliases. Reads are
// combinational from the offset. Assumes NUM_MSG >= 2.
module mbox_regfile
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W       = 64,
    parameter int unsigned ADDR_W       = 5,
    parameter int unsigned NUM_MSG      = 4,
    parameter int unsigned RSP_BASE     = 4,
    parameter int unsigned CTL_DB_BASE  = 16,
    parameter int unsigned HOST_DB_BASE = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic              c_wr,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    output logic              irq_to_ctl,
    output logic              irq_to_host
);

    localparam int unsigned IDX_W = $clog2(NUM_MSG);

    decode_t h_dec;
    decode_t c_dec;

    logic [NUM_MSG-1:0][DATA_W-1:0] cmd_words;
    logic [NUM_MSG-1:0][DATA_W-1:0] rsp_words;
    logic [DATA_W-1:0]              ctl_db;
    logic [DATA_W-1:0]              host_db;

    mbox_decode #(
        .ADDR_W(ADDR_W), .NUM_MSG(NUM_MSG), .RSP_BASE(RSP_BASE),
        .CTL_DB_BASE(CTL_DB_BASE), .HOST_DB_BASE(HOST_DB_BASE)
    ) u_h_dec (
        .addr(h_addr),
        .dec (h_dec)
    );

    mbox_decode #(
        .ADDR_W(ADDR_W), .NUM_MSG(NUM_MSG), .RSP_BASE(RSP_BASE),
        .CTL_DB_BASE(CTL_DB_BASE), .HOST_DB_BASE(HOST_DB_BASE)
    ) u_c_dec (
        .addr(c_addr),
        .dec (c_dec)
    );

    mbox_msg_bank #(
        .DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .IDX_W(IDX_W)
    ) u_cmd_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (h_wr && h_dec.region == RG_CMD),
        .idx  (h_dec.idx[IDX_W-1:0]),
        .wdata(h_wdata),
        .words(cmd_words)
    );

    mbox_msg_bank #(
        .DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .IDX_W(IDX_W)
    ) u_rsp_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (c_wr && c_dec.region == RG_RSP),
        .idx  (c_dec.idx[IDX_W-1:0]),
        .wdata(c_wdata),
        .words(rsp_words)
    );

    mbox_doorbell #(.DATA_W(DATA_W)) u_ctl_db (
        .clk         (clk),
        .rst_n       (rst_n),
        .first_we    (c_wr && c_dec.region == RG_DB_CTL),
        .first_op    (c_dec.op),
        .first_wdata (c_wdata),
        .second_we   (h_wr && h_dec.region == RG_DB_CTL),
        .second_op   (h_dec.op),
        .second_wdata(h_wdata),
        .value       (ctl_db),
        .irq         (irq_to_ctl)
    );

    mbox_doorbell #(.DATA_W(DATA_W)) u_host_db (
        .clk         (clk),
        .rst_n       (rst_n),
        .first_we    (c_wr && c_dec.region == RG_DB_HOST),
        .first_op    (c_dec.op),
        .first_wdata (c_wdata),
        .second_we   (h_wr && h_dec.region == RG_DB_HOST),
        .second_op   (h_dec.op),
        .second_wdata(h_wdata),
        .value       (host_db),
        .irq         (irq_to_host)
    );

    function automatic logic [DATA_W-1:0] read_word(input decode_t d);
        case (d.region)
            RG_CMD:     return cmd_words[d.idx[IDX_W-1:0]];
            RG_RSP:     return rsp_words[d.idx[IDX_W-1:0]];
            RG_DB_CTL:  return ctl_db;
            RG_DB_HOST: return host_db;
            default:    return '0;
        endcase
    endfunction

    // Return the selected word to each bus.
    always_comb begin
        h_rdata = read_word(h_dec);
        c_rdata = read_word(c_dec);
    end

endmodule

// File: rtl/mbox_regfile_checker.sv
// Temporal checks on the mailbox register file, bound to its top module.
// Observes ports only.
module mbox_regfile_checker #(
    parameter int unsigned DATA_W       = 64,
    parameter int unsigned ADDR_W       = 5,
    parameter int unsigned NUM_MSG      = 4,
    parameter int unsigned RSP_BASE     = 4,
    parameter int unsigned CTL_DB_BASE  = 16,
    parameter int unsigned HOST_DB_BASE = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] h_addr,
    input logic              h_wr,
    input logic [DATA_W-1:0] h_wdata,
    input logic [DATA_W-1:0] h_rdata,
    input logic [ADDR_W-1:0] c_addr,
    input logic              c_wr,
    input logic [DATA_W-1:0] c_wdata,
    input logic              irq_to_ctl,
    input logic              irq_to_host
);

    logic [31:0] ha;
    logic [31:0] ca;
    logic        h_unmapped;
    logic        h_on_host_db;

    assign ha = 32'(h_addr);
    assign ca = 32'(c_addr);
    assign h_unmapped = (ha >= NUM_MSG && ha < RSP_BASE) ||
                        (ha >= RSP_BASE + NUM_MSG && ha < CTL_DB_BASE) ||
                        (ha >= HOST_DB_BASE + 3);
    assign h_on_host_db = h_wr && ha >= HOST_DB_BASE && ha < HOST_DB_BASE + 3;

    // R1: interrupts are clear after a reset edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_to_ctl && !irq_to_host));

    // R10: unmapped offsets read as zero.
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        h_unmapped |-> h_rdata == '0);

    // R7: a nonzero host OR into the controller doorbell raises its interrupt.
    p_or_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && ha == CTL_DB_BASE + 2 && h_wdata != '0) |=> irq_to_ctl);

    // R6 and R11: a host AND with zero on its doorbell wins over any controller update.
    p_and_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && ha == HOST_DB_BASE + 1 && h_wdata == '0) |=> !irq_to_host);

    // R5: a lone controller RW write to the host doorbell sets the interrupt level.
    p_rw_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && ca == HOST_DB_BASE && !h_on_host_db)
            |=> (irq_to_host == ($past(c_wdata) != '0)));

    // R4: a controller write to command word 0 does not change it.
    p_cmd_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ha == 0 && $past(ha == 0) && $past(c_wr && ca == 0 && !h_wr))
            |-> $stable(h_rdata));

endmodule

bind mbox_regfile mbox_regfile_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_MSG(NUM_MSG), .RSP_BASE(RSP_BASE),
    .CTL_DB_BASE(CTL_DB_BASE), .HOST_DB_BASE(HOST_DB_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_addr     (h_addr),
    .h_wr       (h_wr),
    .h_wdata    (h_wdata),
    .h_rdata    (h_rdata),
    .c_addr     (c_addr),
    .c_wr       (c_wr),
    .c_wdata    (c_wdata),
    .irq_to_ctl (irq_to_ctl),
    .irq_to_host(irq_to_host)
);

// File: tb/mbox_regfile_bench.sv
// Self-checking bench: random and directed bus traffic against a bench model.
module mbox_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  h_addr = '0;
    logic        h_wr = 1'b0;
    logic [63:0] h_wdata = '0;
    logic [63:0] h_rdata;
    logic [4:0]  c_addr = '0;
    logic        c_wr = 1'b0;
    logic [63:0] c_wdata = '0;
    logic [63:0] c_rdata;
    logic        irq_to_ctl;
    logic        irq_to_host;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_cmd [4];
    logic [63:0] m_rsp [4];
    logic [63:0] m_cdb;
    logic [63:0] m_hdb;

    always #10 clk = ~clk;

    mbox_regfile u_mbox_regfile (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_addr(c_addr), .c_wr(c_wr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .irq_to_ctl(irq_to_ctl), .irq_to_host(irq_to_host)
    );

    function automatic logic [63:0] exp_read(input logic [4:0] a);
        if (a < 4)                return m_cmd[a[1:0]];
        if (a >= 4 && a < 8)      return m_rsp[a[1:0]];
        if (a >= 16 && a < 19)    return m_cdb;
        if (a >= 19 && a < 22)    return m_hdb;
        return 64'd0;
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a < 4)   return "R2 R4";
        if (a < 8)   return "R3 R4";
        if (a < 16)  return "R10";
        if (a < 22)  return "R8";
        return "R10";
    endfunction

    function automatic logic [63:0] db_apply(input logic [63:0] cur, input int op,
                                             input logic [63:0] wd);
        if (op == 1) return cur & wd;
        if (op == 2) return cur | wd;
        return wd;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, check combinational reads and interrupts, update the model.
    task automatic step(input string tag,
                        input logic [4:0] ha, input logic hw, input logic [63:0] hd,
                        input logic [4:0] ca, input logic cw, input logic [63:0] cd);
        @(negedge clk);
        h_addr = ha; h_wr = hw; h_wdata = hd;
        c_addr = ca; c_wr = cw; c_wdata = cd;
        #5;
        check(tag == "" ? tag_of(ha) : tag, h_rdata, exp_read(ha));
        check(tag == "" ? tag_of(ca) : tag, c_rdata, exp_read(ca));
        check("R9", {63'd0, irq_to_ctl},  {63'd0, m_cdb != 0});
        check("R9", {63'd0, irq_to_host}, {63'd0, m_hdb != 0});
        // model: message owners, then controller before host on doorbells
        if (hw && ha < 4)             m_cmd[ha[1:0]] = hd;
        if (cw && ca >= 4 && ca < 8)  m_rsp[ca[1:0]] = cd;
        if (cw && ca >= 16 && ca < 19) m_cdb = db_apply(m_cdb, int'(ca) - 16, cd);
        if (cw && ca >= 19 && ca < 22) m_hdb = db_apply(m_hdb, int'(ca) - 19, cd);
        if (hw && ha >= 16 && ha < 19) m_cdb = db_apply(m_cdb, int'(ha) - 16, hd);
        if (hw && ha >= 19 && ha < 22) m_hdb = db_apply(m_hdb, int'(ha) - 19, hd);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) begin m_cmd[i] = '0; m_rsp[i] = '0; end
        m_cdb = '0; m_hdb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: everything reads zero after reset
        for (int a = 0; a < 22; a++) step("R1", 5'(a), 1'b0, '0, 5'(21 - a), 1'b0, '0);

        // R2, R3: owners write message words
        step("R2", 5'd1, 1'b1, 64'hCAFE_0001_0000_00D4, 5'd6, 1'b1, 64'h1234_5678_9ABC_DEF0);
        step("R3", 5'd6, 1'b0, '0, 5'd1, 1'b0, '0);
        // R4: non-owners write, words stay
        step("R4", 5'd1, 1'b0, '0, 5'd1, 1'b1, 64'hDEAD);
        step("R4", 5'd6, 1'b1, 64'hBEEF, 5'd6, 1'b0, '0);
        step("R4", 5'd6, 1'b0, '0, 5'd1, 1'b0, '0);
        // R12, R7: host sets bit 0 of controller doorbell via set alias
        step("R12", 5'd18, 1'b1, 64'h8000_0000_0000_0000, 5'd16, 1'b0, '0);
        step("R12", 5'd17, 1'b0, '0, 5'd16, 1'b0, '0);
        // R6, R9: controller clears bit 0 with the AND alias
        step("R6", 5'd16, 1'b0, '0, 5'd17, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF);
        step("R9", 5'd16, 1'b0, '0, 5'd18, 1'b0, '0);
        // R5: controller sets response-waiting and ack bits via RW
        step("R5", 5'd19, 1'b0, '0, 5'd19, 1'b1, 64'hC000_0000_0000_0000);
        step("R5", 5'd20, 1'b0, '0, 5'd21, 1'b0, '0);
        // R11: same-cycle collision, controller RW then host OR
        step("R11", 5'd21, 1'b1, 64'h0F, 5'd19, 1'b1, 64'hF0);
        step("R11", 5'd19, 1'b0, '0, 5'd20, 1'b0, '0);
        // R11: controller OR then host AND with zero leaves zero
        step("R11", 5'd20, 1'b1, 64'h0, 5'd21, 1'b1, 64'hFFFF);
        step("R11", 5'd19, 1'b0, '0, 5'd19, 1'b0, '0);
        // R10: unmapped writes ignored
        step("R10", 5'd9, 1'b1, rnd64(), 5'd30, 1'b1, rnd64());
        step("R10", 5'd9, 1'b0, '0, 5'd30, 1'b0, '0);

        // random traffic, doorbell collisions favoured in a quarter of cycles
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] ha = 5'($urandom % 32);
            logic [4:0] ca = 5'($urandom % 32);
            logic [63:0] hd = rnd64();
            logic [63:0] cd = rnd64();
            if ($urandom % 4 == 0) begin
                ha = 5'(16 + $urandom % 6);
                ca = 5'(16 + $urandom % 6);
            end
            if ($urandom % 8 == 0) hd = 64'd0;
            step("", ha, 1'($urandom % 2), hd, ca, 1'($urandom % 2), cd);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule